// File: doc/BRIEF.md
# Speculative Reorder Buffer with In-Order Retirement

This block keeps the results of instructions that have run out of order but must not yet change architectural state. Each instruction gets one slot in a circular buffer when it issues. The slot number goes back to the issue logic as the result tag. Execution units later broadcast a tag with its result. The buffer captures that value and marks the slot complete. Issue logic can read a completed, uncommitted value through the operand read ports, so it does not have to wait for the register file.

Retirement happens only at the oldest slot, and only once its result has arrived. A retiring slot takes one of three paths, chosen by the kind recorded at issue:

- **Ordinary instruction:** it writes the register file.
- **Store:** it writes memory, using the address captured at issue and the data delivered later by broadcast.
- **Branch:** the broadcast value carries the correct successor address, and a flag carries whether the prediction was wrong. A wrong branch raises a redirect and empties the whole buffer in the same cycle. A correct branch retires with no other effect.

Top module: `reorder_buffer`

## Requirements
- R1: After synchronous reset the buffer is empty: `iss_ready` is 1, `iss_tag` is 0, and `rf_we`, `mem_we` and `redirect_valid` are 0.
- R2: An issue is accepted in a cycle with `iss_valid` and `iss_ready` both high. The accepted instruction receives `iss_tag` as its tag, and tags are handed out in increasing order modulo the depth (8), starting from 0.
- R3: With 8 entries held, `iss_ready` is 0. An `iss_valid` in that state allocates nothing, and `iss_tag` stays unchanged.
- R4: A broadcast (`bc_valid`) stores `bc_value` in the entry named by `bc_tag` and marks it complete. A broadcast naming an entry that is not allocated has no effect.
- R5: Only the oldest entry retires, and only once complete. A kind-0 entry (ordinary; kind 3 behaves the same) raises `rf_we` for exactly that cycle, with its destination on `rf_addr` and its value on `rf_data`, and the entry is freed.
- R6: A kind-1 entry (store) retires with `mem_we`, `mem_addr` equal to the address given at issue, `mem_data` equal to the broadcast value, and `rf_we` low.
- R7: A kind-2 entry (branch) whose broadcast carried `bc_misp`=1 retires with `redirect_valid` and `redirect_pc` equal to its broadcast value. All entries are discarded in that same cycle: `iss_ready` is 0 during it, and the next cycle shows an empty buffer with `iss_tag` 0.
- R8: A kind-2 entry with `bc_misp`=0 retires with `rf_we`, `mem_we` and `redirect_valid` all low.
- R9: Each read port reports `rd_ready` high exactly when its tag names an allocated, complete entry. In that case it also returns that entry's value.
- R10: An accepted issue and a retirement in the same cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | 0 ordinary, 1 store, 2 branch, 3 ordinary |
| iss_dest | input | REG_W | Destination register |
| iss_addr | input | DATA_W | Store address |
| iss_ready | output | 1 | A slot can be allocated this cycle |
| iss_tag | output | TAG_W | Tag given to the instruction issued this cycle |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Entry the broadcast fills |
| bc_value | input | DATA_W | Result, store data or correct branch target |
| bc_misp | input | 1 | Branch was mispredicted |
| rd_tag | input | NUM_RD*TAG_W | Operand read tags, port p at bits p*TAG_W |
| rd_value | output | NUM_RD*DATA_W | Operand values |
| rd_ready | output | NUM_RD | Operand present in buffer |
| rf_we | output | 1 | Register file write |
| rf_addr | output | REG_W | Register written |
| rf_data | output | DATA_W | Value written |
| mem_we | output | 1 | Memory write |
| mem_addr | output | DATA_W | Store address |
| mem_data | output | DATA_W | Store data |
| redirect_valid | output | 1 | Mispredicted branch retired, buffer flushed |
| redirect_pc | output | DATA_W | Correct successor address |

## Verification
The bench fills the buffer with no broadcasts, then keeps issuing while it is full. A design that let a ninth issue through would overwrite the oldest slot and retire the wrong value. Broadcasts arrive out of order, and some name freed slots. A design that did not check allocation would mark a stale slot complete, which shows up as a false `rd_ready`.

Mispredicted branches are retired while issue and broadcasts continue. A design that accepted the issue in the flush cycle, or kept any valid bit, would hand out a tag other than 0 afterwards. The bench also puts an issue and a retirement in the same cycle, where a wrong occupancy count shows up as an early or late stall.

// File: rtl/rob_pkg.sv
package rob_pkg;

    parameter int ROB_DEPTH    = 8;
    parameter int ROB_DATA_W   = 32;
    parameter int ROB_REG_W    = 5;
    parameter int ROB_RD_PORTS = 2;

    typedef enum logic [1:0] {
        KIND_ALU    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2,
        KIND_SPARE  = 2'd3
    } kind_e;

    typedef struct packed {
        logic retire;
        logic rf_we;
        logic mem_we;
        logic redirect;
    } retire_act_t;

    function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
        return (p + 1 == depth) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic             retire,
    input  logic             flush,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    import rob_pkg::*;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (alloc)  tail <= TAG_W'(wrap_inc(int'(tail), DEPTH));
            if (retire) head <= TAG_W'(wrap_inc(int'(head), DEPTH));
            case ({alloc, retire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign full = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/rob_store.sv
module rob_store #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 32,
    parameter int REG_W  = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  logic                alloc_en,
    input  logic [TAG_W-1:0]    alloc_idx,
    input  rob_pkg::kind_e      alloc_kind,
    input  logic [REG_W-1:0]    alloc_dest,
    input  logic [DATA_W-1:0]   alloc_addr,
    input  logic                bc_en,
    input  logic [TAG_W-1:0]    bc_idx,
    input  logic [DATA_W-1:0]   bc_value,
    input  logic                bc_misp,
    input  logic                free_en,
    input  logic [TAG_W-1:0]    free_idx,
    output logic [DEPTH-1:0]    valid_q,
    output logic [DEPTH-1:0]    done_q,
    output logic [DEPTH-1:0]    misp_q,
    output rob_pkg::kind_e      kind_q  [DEPTH],
    output logic [REG_W-1:0]    dest_q  [DEPTH],
    output logic [DATA_W-1:0]   addr_q  [DEPTH],
    output logic [DATA_W-1:0]   value_q [DEPTH]
);
    logic bc_hit;
    assign bc_hit = bc_en && valid_q[bc_idx];

    // status bits: flush wins, then broadcast, free, allocate
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= '0;
            done_q  <= '0;
            misp_q  <= '0;
        end else begin
            if (bc_hit) begin
                done_q[bc_idx] <= 1'b1;
                misp_q[bc_idx] <= bc_misp;
            end
            if (free_en) valid_q[free_idx] <= 1'b0;
            if (alloc_en) begin
                valid_q[alloc_idx] <= 1'b1;
                done_q[alloc_idx]  <= 1'b0;
                misp_q[alloc_idx]  <= 1'b0;
            end
        end
    end

    // payload needs no reset: only read behind a set valid bit
    always_ff @(posedge clk) begin
        if (alloc_en) begin
            kind_q[alloc_idx] <= alloc_kind;
            dest_q[alloc_idx] <= alloc_dest;
            addr_q[alloc_idx] <= alloc_addr;
        end
        if (bc_hit) value_q[bc_idx] <= bc_value;
    end
endmodule

// File: rtl/rob_retire.sv
module rob_retire (
    input  logic                 head_valid,
    input  logic                 head_done,
    input  logic                 head_misp,
    input  rob_pkg::kind_e       head_kind,
    output rob_pkg::retire_act_t act
);
    import rob_pkg::*;

    always_comb begin
        act        = '0;
        act.retire = head_valid && head_done;
        if (act.retire) begin
            unique case (head_kind)
                KIND_STORE:  act.mem_we   = 1'b1;
                KIND_BRANCH: act.redirect = head_misp;
                default:     act.rf_we    = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer #(
    parameter int DEPTH  = rob_pkg::ROB_DEPTH,
    parameter int DATA_W = rob_pkg::ROB_DATA_W,
    parameter int REG_W  = rob_pkg::ROB_REG_W,
    parameter int NUM_RD = rob_pkg::ROB_RD_PORTS,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     iss_valid,
    input  logic [1:0]               iss_kind,
    input  logic [REG_W-1:0]         iss_dest,
    input  logic [DATA_W-1:0]        iss_addr,
    output logic                     iss_ready,
    output logic [TAG_W-1:0]         iss_tag,
    input  logic                     bc_valid,
    input  logic [TAG_W-1:0]         bc_tag,
    input  logic [DATA_W-1:0]        bc_value,
    input  logic                     bc_misp,
    input  logic [NUM_RD*TAG_W-1:0]  rd_tag,
    output logic [NUM_RD*DATA_W-1:0] rd_value,
    output logic [NUM_RD-1:0]        rd_ready,
    output logic                     rf_we,
    output logic [REG_W-1:0]         rf_addr,
    output logic [DATA_W-1:0]        rf_data,
    output logic                     mem_we,
    output logic [DATA_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_data,
    output logic                     redirect_valid,
    output logic [DATA_W-1:0]        redirect_pc
);
    import rob_pkg::*;

    logic [TAG_W-1:0]  head, tail;
    logic [CNT_W-1:0]  occ;
    logic              full, alloc;
    retire_act_t       act;
    logic [DEPTH-1:0]  valid_q, done_q, misp_q;
    kind_e             kind_q  [DEPTH];
    logic [REG_W-1:0]  dest_q  [DEPTH];
    logic [DATA_W-1:0] addr_q  [DEPTH];
    logic [DATA_W-1:0] value_q [DEPTH];

    assign iss_ready = !full && !act.redirect;
    assign alloc     = iss_valid && iss_ready;
    assign iss_tag   = tail;

    rob_ptrs #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) i_ptrs (
        .clk(clk), .rst(rst), .alloc(alloc), .retire(act.retire),
        .flush(act.redirect), .head(head), .tail(tail), .count(occ), .full(full)
    );

    rob_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .REG_W(REG_W)) i_store (
        .clk(clk), .rst(rst), .flush(act.redirect),
        .alloc_en(alloc), .alloc_idx(tail), .alloc_kind(kind_e'(iss_kind)),
        .alloc_dest(iss_dest), .alloc_addr(iss_addr),
        .bc_en(bc_valid), .bc_idx(bc_tag), .bc_value(bc_value), .bc_misp(bc_misp),
        .free_en(act.retire), .free_idx(head),
        .valid_q(valid_q), .done_q(done_q), .misp_q(misp_q),
        .kind_q(kind_q), .dest_q(dest_q), .addr_q(addr_q), .value_q(value_q)
    );

    rob_retire i_retire (
        .head_valid(valid_q[head]), .head_done(done_q[head]),
        .head_misp(misp_q[head]), .head_kind(kind_q[head]), .act(act)
    );

    assign rf_we          = act.rf_we;
    assign rf_addr        = dest_q[head];
    assign rf_data        = value_q[head];
    assign mem_we         = act.mem_we;
    assign mem_addr       = addr_q[head];
    assign mem_data       = value_q[head];
    assign redirect_valid = act.redirect;
    assign redirect_pc    = value_q[head];

    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        logic [TAG_W-1:0] t;
        assign t                             = rd_tag[g*TAG_W +: TAG_W];
        assign rd_ready[g]                   = valid_q[t] && done_q[t];
        assign rd_value[g*DATA_W +: DATA_W]  = value_q[t];
    end
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 3,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic [TAG_W-1:0] iss_tag,
    input logic             rf_we,
    input logic             mem_we,
    input logic             redirect_valid,
    input logic [CNT_W-1:0] occ
);
    AST_ONE_RETIRE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rf_we, mem_we, redirect_valid})); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH)); // R3

    AST_TAG_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready) |=> iss_tag == TAG_W'($past(iss_tag) + 1'b1)); // R2

    AST_STALL_HOLDS_TAG: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready && !redirect_valid) |=> $stable(iss_tag)); // R3

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |=> (occ == '0 && iss_tag == '0 && !rf_we && !mem_we && !redirect_valid)); // R7

    AST_PAIR_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready && (rf_we || mem_we)) |=> $stable(occ)); // R10
endmodule

bind reorder_buffer rob_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) i_rob_checker (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_tag(iss_tag), .rf_we(rf_we), .mem_we(mem_we),
    .redirect_valid(redirect_valid), .occ(occ)
);

// File: tb/test_reorder_buffer.sv
`timescale 1ns/1ps
module test_reorder_buffer;
    localparam int DEPTH = 8, TAG_W = 3, DATA_W = 32, REG_W = 5, NRD = 2;
    localparam int NCYC  = 4000;

    logic clk = 0, rst = 1;
    logic iss_valid = 0; logic [1:0] iss_kind = 0;
    logic [REG_W-1:0] iss_dest = 0; logic [DATA_W-1:0] iss_addr = 0;
    logic iss_ready; logic [TAG_W-1:0] iss_tag;
    logic bc_valid = 0; logic [TAG_W-1:0] bc_tag = 0;
    logic [DATA_W-1:0] bc_value = 0; logic bc_misp = 0;
    logic [NRD*TAG_W-1:0] rd_tag = 0; logic [NRD*DATA_W-1:0] rd_value; logic [NRD-1:0] rd_ready;
    logic rf_we, mem_we, redirect_valid;
    logic [REG_W-1:0] rf_addr;
    logic [DATA_W-1:0] rf_data, mem_addr, mem_data, redirect_pc;

    reorder_buffer i_reorder_buffer (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_kind(iss_kind),
        .iss_dest(iss_dest), .iss_addr(iss_addr), .iss_ready(iss_ready), .iss_tag(iss_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value), .bc_misp(bc_misp),
        .rd_tag(rd_tag), .rd_value(rd_value), .rd_ready(rd_ready),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    always #4 clk = ~clk;

    int tests = 0, fails = 0;
    bit finished = 0;

    // behavioural model: program-order queue of tags plus per-tag payload
    int q[$];
    int m_tail = 0;
    bit m_done [DEPTH];
    bit m_misp [DEPTH];
    int m_kind [DEPTH];
    int m_dest [DEPTH];
    logic [DATA_W-1:0] m_addr [DEPTH];
    logic [DATA_W-1:0] m_val  [DEPTH];

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit in_q(int t);
        foreach (q[i]) if (q[i] == t) return 1;
        return 0;
    endfunction

    initial begin
        #(8 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit prev_both = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            bit fire, e_rf, e_mem, e_red, e_ready, acc, bc_hit;
            int h;
            // stimulus
            if (cyc == 0) begin
                iss_valid = 0; bc_valid = 0;
            end else begin
                iss_valid = (cyc < 30) ? 1'b1 : ($urandom % 3 != 0);
                iss_kind  = 2'($urandom % 3);
                iss_dest  = REG_W'($urandom);
                iss_addr  = $urandom;
                bc_valid  = (cyc < 30 || cyc % 500 < 40) ? 1'b0 : ($urandom % 2 == 0);
                if (q.size() > 0 && $urandom % 4 != 0) bc_tag = TAG_W'(q[$urandom % q.size()]);
                else bc_tag = TAG_W'($urandom);
                bc_value  = $urandom;
                bc_misp   = ($urandom % 5 == 0);
            end
            for (int p = 0; p < NRD; p++) rd_tag[p*TAG_W +: TAG_W] = TAG_W'($urandom);
            #1;
            // expected outputs from model state
            h     = (q.size() > 0) ? q[0] : 0;
            fire  = (q.size() > 0) && m_done[h];
            e_rf  = fire && (m_kind[h] == 0);
            e_mem = fire && (m_kind[h] == 1);
            e_red = fire && (m_kind[h] == 2) && m_misp[h];
            e_ready = (q.size() < DEPTH) && !e_red;
            if (cyc == 0) begin
                chk("R1", "reset iss_ready", 64'(iss_ready), 64'(1));
                chk("R1", "reset iss_tag", 64'(iss_tag), 64'(0));
                chk("R1", "reset commit outputs", 64'({rf_we, mem_we, redirect_valid}), 64'(0));
            end
            chk("R2", "iss_tag", 64'(iss_tag), 64'(m_tail));
            chk(prev_both ? "R10" : (q.size() == DEPTH ? "R3" : (e_red ? "R7" : "R2")),
                "iss_ready", 64'(iss_ready), 64'(e_ready));
            chk("R5", "rf_we", 64'(rf_we), 64'(e_rf));
            if (e_rf) begin
                chk("R5", "rf_addr", 64'(rf_addr), 64'(m_dest[h]));
                chk("R5", "rf_data", 64'(rf_data), 64'(m_val[h]));
            end
            chk("R6", "mem_we", 64'(mem_we), 64'(e_mem));
            if (e_mem) begin
                chk("R6", "mem_addr", 64'(mem_addr), 64'(m_addr[h]));
                chk("R6", "mem_data", 64'(mem_data), 64'(m_val[h]));
            end
            chk("R7", "redirect_valid", 64'(redirect_valid), 64'(e_red));
            if (e_red) chk("R7", "redirect_pc", 64'(redirect_pc), 64'(m_val[h]));
            if (fire && m_kind[h] == 2 && !m_misp[h])
                chk("R8", "quiet branch retire", 64'({rf_we, mem_we, redirect_valid}), 64'(0));
            for (int p = 0; p < NRD; p++) begin
                int t;
                bit er;
                t  = int'(rd_tag[p*TAG_W +: TAG_W]);
                er = in_q(t) && m_done[t];
                chk("R9", "rd_ready", 64'(rd_ready[p]), 64'(er));
                if (er) chk("R4", "rd_value", 64'(rd_value[p*DATA_W +: DATA_W]), 64'(m_val[t]));
            end
            // advance model at the clock edge
            acc    = iss_valid && e_ready;
            bc_hit = bc_valid && in_q(int'(bc_tag));
            @(posedge clk);
            prev_both = 0;
            if (e_red) begin
                q.delete();
                m_tail = 0;
                foreach (m_done[i]) m_done[i] = 0;
            end else begin
                if (fire) void'(q.pop_front());
                if (bc_hit) begin
                    m_done[bc_tag] = 1;
                    m_val[bc_tag]  = bc_value;
                    m_misp[bc_tag] = bc_misp;
                end
                if (acc) begin
                    q.push_back(m_tail);
                    m_kind[m_tail] = int'(iss_kind);
                    m_dest[m_tail] = int'(iss_dest);
                    m_addr[m_tail] = iss_addr;
                    m_done[m_tail] = 0;
                    m_misp[m_tail] = 0;
                    m_tail = (m_tail + 1) % DEPTH;
                end
                prev_both = acc && fire;
            end
            @(negedge clk);
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule